// File: doc/BRIEF.md
# Vector Element Address Sequencer

This block turns one vectorised load or store, whose base register is a scalar, into a stream of per-element effective addresses. A single start pulse carries the setup. That setup is the base value, a flag that says the base register number is zero, a 16-bit signed displacement, the access size in bytes, a shift amount, the vector length and an addressing mode.

The block then offers one address per cycle on a valid/ready handshake, with the element index next to it. After the last element has been accepted it pulses a done flag. The memory pipeline downstream consumes the stream. It can stall the stream at any time by holding ready low.

Three addressing modes are supported:
- **Contiguous.** Elements follow each other at the access size.
- **Strided.** The displacement is the distance between elements.
- **Bit-reversed.** The element index is bit-reversed, which gives the butterfly ordering of a radix-2 FFT pass. A final left shift scales the result to wider radix-2 spans.

Setups the block cannot honour are rejected with an error pulse. A rejected setup issues no addresses.

Top module: `vls_addr_seq`

## Requirements
- R1: With mode code 0 (contiguous), element i has address B + D + S*i. B is the base term, D is the sign-extended displacement and S is the access size in bytes.
- R2: With mode code 1 (strided) and a nonzero displacement, element i has address B + D*i. With mode code 1 and a zero displacement, the R1 formula applies.
- R3: With mode code 2 (bit-reversed), element i has address B + ((D*S*rev(i)) << sh). Here rev reverses the low log2(VL) bits of i. For VL=4 the indices 0,1,2,3 become 0,2,1,3, and for VL=1 rev(0)=0.
- R4: When the base-is-register-zero flag is set, the base term B is 0 whatever the base input carries.
- R5: The first address offered after a start carries index 0. The index then rises by one per accepted element, up to VL-1.
- R6: In the cycle after the element with index VL-1 is accepted, done is high for exactly one cycle and valid is low.
- R7: While valid is high and ready is low, the address and index outputs do not change, and valid stays high.
- R8: A start that arrives while a sequence is being offered (valid high) is ignored. The running sequence completes with its own addresses and no further sequence follows.
- R9: A start is rejected in any of these cases:
  - VL is outside 1..64.
  - The size is not one of 1, 2, 4 or 8.
  - The mode code is 3.
  - The mode code is 2 and VL is not a power of two.
  A rejected start raises err for exactly one cycle, the cycle after the start, and produces neither valid nor done.
- R10: The displacement is sign-extended to 64 bits, and all address arithmetic wraps modulo 2^64.
- R11: During and right after a synchronous reset, valid, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request that launches a sequence |
| base | input | 64 | Base register value |
| base_zero | input | 1 | Base register number is zero, so the base term is 0 |
| disp | input | 16 | Signed displacement |
| size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| shamt | input | 6 | Left shift applied in bit-reversed mode |
| vl | input | 7 | Vector length |
| mode | input | 2 | 0 contiguous, 1 strided, 2 bit-reversed |
| out_ready | input | 1 | Consumer accepts the offered address |
| out_valid | output | 1 | An address is offered |
| out_addr | output | 64 | Effective address of the offered element |
| out_idx | output | 6 | Index of the offered element |
| done | output | 1 | One-cycle pulse after the last element is accepted |
| err | output | 1 | One-cycle pulse for a rejected start |

## Verification
The handshake properties assume two things about the consumer:
- Ready may change freely, but it is only meaningful while valid is high.
- Reset is applied from time zero.

They do not depend on the start inputs staying legal, so the bench feeds rejected setups and starts during a busy sequence on purpose. The stimulus keeps a start to a single cycle and holds the setup fields steady only in that cycle, which matches the one-shot capture the block performs. Stall patterns come from a fixed per-vector pattern, so every stall case can be repeated exactly.

// File: rtl/vls_pkg.sv
package vls_pkg;

    parameter int ADDR_W  = 64;
    parameter int DISP_W  = 16;
    parameter int MAX_VL  = 64;
    parameter int IDX_W   = $clog2(MAX_VL);
    parameter int VL_W    = IDX_W + 1;
    parameter int SIZE_W  = 4;
    parameter int SHAMT_W = $clog2(ADDR_W);
    parameter int LG_W    = 2;
    parameter int REV_W   = $clog2(IDX_W + 1);

    typedef enum logic [1:0] {
        MODE_UNIT = 2'd0,
        MODE_ELEM = 2'd1,
        MODE_BREV = 2'd2,
        MODE_RSVD = 2'd3
    } mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [ADDR_W-1:0]  disp;
        logic [LG_W-1:0]    lg_size;
        logic [SHAMT_W-1:0] shamt;
        logic [IDX_W-1:0]   last;
        logic [REV_W-1:0]   rev_bits;
        mode_e              mode;
    } cfg_t;

    function automatic logic size_ok(input logic [SIZE_W-1:0] s);
        return (s == SIZE_W'(1)) || (s == SIZE_W'(2)) ||
               (s == SIZE_W'(4)) || (s == SIZE_W'(8));
    endfunction

    function automatic logic [LG_W-1:0] size_lg(input logic [SIZE_W-1:0] s);
        logic [LG_W-1:0] r;
        case (s)
            SIZE_W'(2): r = LG_W'(1);
            SIZE_W'(4): r = LG_W'(2);
            SIZE_W'(8): r = LG_W'(3);
            default:    r = LG_W'(0);
        endcase
        return r;
    endfunction

    function automatic logic is_pow2(input logic [VL_W-1:0] v);
        return (v != '0) && ((v & (v - VL_W'(1))) == '0);
    endfunction

    function automatic logic [REV_W-1:0] vl_lg(input logic [VL_W-1:0] v);
        logic [REV_W-1:0] r;
        r = '0;
        for (int k = 0; k < VL_W; k++)
            if (v[k]) r = REV_W'(k);
        return r;
    endfunction

    function automatic logic [IDX_W-1:0] bit_rev(input logic [IDX_W-1:0] i,
                                                 input logic [REV_W-1:0] nb);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int k = 0; k < IDX_W; k++)
            if (k < int'(nb)) r[int'(nb) - 1 - k] = i[k];
        return r;
    endfunction

endpackage

// File: rtl/vls_cfg_latch.sv
module vls_cfg_latch
    import vls_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               idle,
    input  logic [ADDR_W-1:0]  base,
    input  logic               base_zero,
    input  logic [DISP_W-1:0]  disp,
    input  logic [SIZE_W-1:0]  size,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [VL_W-1:0]    vl,
    input  logic [1:0]         mode,
    output cfg_t               cfg,
    output logic               go,
    output logic               err
);

    logic  bad;
    mode_e req_mode;

    always_comb begin
        req_mode = mode_e'(mode);
        bad = !size_ok(size) || (vl == '0) || (vl > VL_W'(MAX_VL)) ||
              (req_mode == MODE_RSVD) ||
              ((req_mode == MODE_BREV) && !is_pow2(vl));
        go  = start && idle && !bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            err <= 1'b0;
        end else begin
            err <= start && idle && bad;
            if (go) begin
                cfg.base     <= base_zero ? '0 : base;
                cfg.disp     <= ADDR_W'($signed(disp));
                cfg.lg_size  <= size_lg(size);
                cfg.shamt    <= shamt;
                cfg.last     <= IDX_W'(vl - VL_W'(1));
                cfg.rev_bits <= vl_lg(vl);
                cfg.mode     <= ((req_mode == MODE_ELEM) && (disp == '0)) ?
                                MODE_UNIT : req_mode;
            end
        end
    end

endmodule

// File: rtl/vls_idx_ctr.sv
module vls_idx_ctr
    import vls_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [IDX_W-1:0] last,
    input  logic             ready,
    output logic             valid,
    output logic [IDX_W-1:0] idx,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            idx   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                valid <= 1'b1;
                idx   <= '0;
            end else if (valid && ready) begin
                if (idx == last) begin
                    valid <= 1'b0;
                    done  <= 1'b1;
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
    import vls_pkg::*;
(
    input  cfg_t              cfg,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] idx_w;
    logic [ADDR_W-1:0] rev_w;
    logic [ADDR_W-1:0] off;

    always_comb begin
        idx_w = ADDR_W'(idx);
        rev_w = ADDR_W'(bit_rev(idx, cfg.rev_bits));
        case (cfg.mode)
            MODE_ELEM: off = cfg.disp * idx_w;
            MODE_BREV: off = ((cfg.disp << cfg.lg_size) * rev_w) << cfg.shamt;
            default:   off = cfg.disp + (idx_w << cfg.lg_size);
        endcase
        addr = cfg.base + off;
    end

endmodule

// File: rtl/vls_addr_seq.sv
module vls_addr_seq
    import vls_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [ADDR_W-1:0]  base,
    input  logic               base_zero,
    input  logic [DISP_W-1:0]  disp,
    input  logic [SIZE_W-1:0]  size,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [VL_W-1:0]    vl,
    input  logic [1:0]         mode,
    input  logic               out_ready,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [IDX_W-1:0]   out_idx,
    output logic               done,
    output logic               err
);

    cfg_t cfg;
    logic go;

    vls_cfg_latch u_cfg (
        .clk(clk), .rst(rst), .start(start), .idle(!out_valid),
        .base(base), .base_zero(base_zero), .disp(disp), .size(size),
        .shamt(shamt), .vl(vl), .mode(mode),
        .cfg(cfg), .go(go), .err(err)
    );

    vls_idx_ctr u_ctr (
        .clk(clk), .rst(rst), .go(go), .last(cfg.last), .ready(out_ready),
        .valid(out_valid), .idx(out_idx), .done(done)
    );

    vls_addr_gen u_gen (
        .cfg(cfg), .idx(out_idx), .addr(out_addr)
    );

endmodule

// File: rtl/vls_addr_seq_chk.sv
module vls_addr_seq_chk
    import vls_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ADDR_W-1:0] out_addr,
    input logic [IDX_W-1:0]  out_idx,
    input logic              done,
    input logic              err
);

    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_idx));

    p_first_idx_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> out_idx == '0);

    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid && out_ready) |-> out_idx == IDX_W'($past(out_idx) + 1'b1));

    p_done_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid && $past(out_valid && out_ready));

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> !out_valid && !done);

endmodule

bind vls_addr_seq vls_addr_seq_chk u_chk (
    .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_idx(out_idx), .done(done), .err(err)
);

// File: tb/vls_addr_seq_tb.sv
module vls_addr_seq_tb;

    typedef struct packed {
        logic [1:0]  mode;
        logic [63:0] base;
        logic        bz;
        logic [15:0] disp;
        logic [3:0]  size;
        logic [5:0]  sh;
        logic [6:0]  vl;
        logic        stall;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 64'h10,               1'b0, 16'd8,    4'd4, 6'd0, 7'd2,  1'b0}, // R1
        '{2'd1, 64'h10,               1'b0, 16'd24,   4'd4, 6'd0, 7'd2,  1'b1}, // R2
        '{2'd1, 64'h100,              1'b0, 16'd0,    4'd8, 6'd0, 7'd3,  1'b0}, // R2 fallback
        '{2'd2, 64'h10,               1'b0, 16'd4,    4'd4, 6'd0, 7'd4,  1'b1}, // R3
        '{2'd2, 64'h4000,             1'b0, 16'd1,    4'd8, 6'd2, 7'd8,  1'b0}, // R3 shift
        '{2'd0, 64'hDEAD,             1'b1, 16'hFFFC, 4'd2, 6'd0, 7'd5,  1'b1}, // R4 R10
        '{2'd1, 64'h1000,             1'b0, 16'hFFF0, 4'd1, 6'd0, 7'd6,  1'b0}, // R10
        '{2'd0, 64'hFFFFFFFFFFFFFFF0, 1'b0, 16'd0,    4'd1, 6'd0, 7'd64, 1'b1}, // R10 wrap
        '{2'd2, 64'h77,               1'b0, 16'd5,    4'd2, 6'd3, 7'd1,  1'b0}  // R3 VL=1
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [63:0] base = '0;
    logic        base_zero = 1'b0;
    logic [15:0] disp = '0;
    logic [3:0]  size = 4'd1;
    logic [5:0]  shamt = '0;
    logic [6:0]  vl = 7'd1;
    logic [1:0]  mode = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [63:0] out_addr;
    logic [5:0]  out_idx;
    logic        done;
    logic        err;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    vls_addr_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .base(base), .base_zero(base_zero),
        .disp(disp), .size(size), .shamt(shamt), .vl(vl), .mode(mode),
        .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
        .out_idx(out_idx), .done(done), .err(err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input vec_t v, input int k);
        logic [63:0] b, d;
        int nb, r;
        b  = v.bz ? 64'd0 : v.base;
        d  = {{48{v.disp[15]}}, v.disp};
        nb = 0;
        while ((1 << nb) < int'(v.vl)) nb++;
        r = 0;
        for (int j = 0; j < nb; j++)
            if (k[j]) r |= (1 << (nb - 1 - j));
        case (v.mode)
            2'd1: if (v.disp != 0) return b + d * 64'(k);
            2'd2: return b + ((d * 64'(v.size) * 64'(r)) << v.sh);
            default: ;
        endcase
        return b + d + 64'(k) * 64'(v.size);
    endfunction

    task automatic start_vec(input vec_t v);
        @(negedge clk);
        mode = v.mode; base = v.base; base_zero = v.bz; disp = v.disp;
        size = v.size; shamt = v.sh; vl = v.vl; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain(input vec_t v);
        int k = 0;
        int g = 0;
        while (k < int'(v.vl) && g < 2000) begin
            out_ready = v.stall ? ((g % 3) != 2) : 1'b1;
            if (out_valid && out_ready) begin
                check("R5 idx", 64'(out_idx), 64'(k));
                check("R1/R2/R3/R4/R10 addr", out_addr, model(v, k));
                k++;
            end
            @(negedge clk);
            g++;
        end
        check("R6 done high", 64'(done), 64'd1);
        check("R6 valid low at done", 64'(out_valid), 64'd0);
        out_ready = 1'b0;
        @(negedge clk);
        check("R6 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic err_case(input logic [1:0] m, input logic [3:0] s, input logic [6:0] l);
        vec_t v;
        v = '{m, 64'h500, 1'b0, 16'd4, s, 6'd0, l, 1'b0};
        out_ready = 1'b1;
        start_vec(v);
        check("R9 err raised", 64'(err), 64'd1);
        check("R9 no valid", 64'(out_valid), 64'd0);
        @(negedge clk);
        check("R9 err one cycle", 64'(err), 64'd0);
        check("R9 still no valid", 64'(out_valid), 64'd0);
        check("R9 no done", 64'(done), 64'd0);
        out_ready = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t a;
        repeat (3) @(negedge clk);
        check("R11 valid in reset", 64'(out_valid), 64'd0);
        check("R11 done in reset", 64'(done), 64'd0);
        check("R11 err in reset", 64'(err), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 valid after reset", 64'(out_valid), 64'd0);

        for (int n = 0; n < NV; n++) begin
            start_vec(TBL[n]);
            drain(TBL[n]);
        end

        // R7 and R8: stall at element 0, try a second start meanwhile
        a = '{2'd0, 64'h2000, 1'b0, 16'd0, 4'd4, 6'd0, 7'd3, 1'b0};
        out_ready = 1'b0;
        start_vec(a);
        for (int c = 0; c < 3; c++) begin
            check("R7 valid held", 64'(out_valid), 64'd1);
            check("R7 addr held", out_addr, model(a, 0));
            check("R7 idx held", 64'(out_idx), 64'd0);
            if (c == 1) begin
                base = 64'h9000; vl = 7'd2; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        drain(a);
        check("R8 no second sequence", 64'(out_valid), 64'd0);

        err_case(2'd2, 4'd4, 7'd6);   // R9 non-power-of-two in bit-reversed
        err_case(2'd0, 4'd4, 7'd0);   // R9 VL zero
        err_case(2'd0, 4'd4, 7'd65);  // R9 VL too large
        err_case(2'd0, 4'd3, 7'd2);   // R9 bad size
        err_case(2'd3, 4'd4, 7'd2);   // R9 reserved mode

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule